// File: doc/BRIEF.md
# LIN Slave Header Detector

This block watches the receive line of a LIN bus node that acts as a slave. It finds the Synch Break by timing how long the line stays low against a programmed width. It then times the Synch Field, which is the 0x55 byte, and returns a count from which the bit rate can be derived. A down-counter sets the break width. The break counter and the synch-field counter both run on a tick taken from one of four sources: the plain clock, the clock divided by two, the clock divided by eight, or pulses from a separate oscillator.

The block sits between the receive pin and a UART receiver. It holds the UART's receive input at the idle-high level until a chosen point in the header. One control bit picks that point: right after the break, so that the UART also sees the Synch Field, or only after the Synch Field has been measured. Three events set sticky status flags: break detected, synch field measured, and bus collision. Writing 1 to a flag clears it. An interrupt line combines each flag with its own enable.

Configuration stays in place between frames. Once a header has completed, the block keeps watching for the next break with the same settings.

Top module: `lin_hdr_rx`

## Requirements
- R1: With `cfg_en`=1 (and `cfg_master`=0), the block leaves idle one cycle later and hunts for a break. With `cfg_en`=0, `uart_rxd` is held at 1 in that same cycle, and the partly received header is dropped from the next cycle on.
- R2: With `cfg_master`=1, the block stays idle: no break or synch event is raised, and `uart_rxd` stays at 1.
- R3: With the undivided source, `flag_brk` becomes 1 after the line has been sampled low on `cfg_brk_width` consecutive clock edges. A low run one edge shorter raises no flag.
- R4: `cfg_clk_sel` encodes the tick source as 0 = every clock, 1 = clock/2, 2 = clock/8, 3 = each cycle in which `osc_tick` is 1. The break width is counted in ticks of the chosen source.
- R5: After a break, `sf_count` captures the number of ticks from the first falling edge that follows the break's high level up to the fifth falling edge, and `flag_sf` is set. With the undivided source this equals 8 times the bit period in cycles.
- R6: With `cfg_unmask_early`=0, `uart_rxd` stays at 1 through the break and the Synch Field. It follows `rx_pin` once the synch measurement is complete.
- R7: With `cfg_unmask_early`=1, `uart_rxd` follows `rx_pin` from the cycle after break detection, so the UART receives the Synch Field as well.
- R8: The flags are sticky. `flag_clr` bit 2 clears `flag_brk`, bit 1 clears `flag_sf` and bit 0 clears `flag_col`, each when written as 1. A new event in the same cycle as a clear wins, and the flag stays 1.
- R9: `irq` is 1 exactly when some flag is 1 and its enable (`ie_brk`, `ie_sf`, `ie_col`) is 1.
- R10: While the block is active, a cycle with `bit_sample`=1, `tx_out`=1 and `rx_pin`=0 sets `flag_col`. No other combination sets it.
- R11: After a completed header, a new break starts the next header with no reprogramming. Disabling and then re-enabling also restarts header reception with the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Start (1) or stop (0) header reception |
| cfg_master | input | 1 | Mode select; 0 = slave, 1 = block held idle |
| cfg_clk_sel | input | 2 | Tick source select |
| cfg_brk_width | input | CW | Break width in ticks |
| cfg_unmask_early | input | 1 | 1 = unmask after break, 0 = after synch field |
| ie_brk | input | 1 | Interrupt enable, break detected |
| ie_sf | input | 1 | Interrupt enable, synch field measured |
| ie_col | input | 1 | Interrupt enable, bus collision |
| flag_clr | input | 3 | Write-1-to-clear: {brk, sf, col} |
| osc_tick | input | 1 | Pulses from the separate oscillator source |
| rx_pin | input | 1 | Bus receive line, synchronous to clk |
| tx_out | input | 1 | Level being driven onto the bus |
| bit_sample | input | 1 | Bit sample strobe from the UART |
| uart_rxd | output | 1 | Gated receive line toward the UART |
| flag_brk | output | 1 | Break detected flag |
| flag_sf | output | 1 | Synch field measured flag |
| flag_col | output | 1 | Bus collision flag |
| sf_count | output | CW | Captured synch field length in ticks |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `rx_pin` already arrives synchronous to `clk`, that `cfg_clk_sel` changes only while no measurement depends on it, and that `cfg_brk_width` is at least 1. The bench changes every input on the falling clock edge. It switches the tick source only between headers, after a disable or a detected break, and it draws break widths and bit periods from ranges in which a Synch Field low run never reaches the break width. Random headers vary the bit period, the break length and the unmask point. Directed cases cover the break width boundary, each divided source, the oscillator pulses, the clear/set collision and the interrupt enables.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    typedef enum logic [1:0] {
        CKS_DIV1 = 2'd0,
        CKS_DIV2 = 2'd1,
        CKS_DIV8 = 2'd2,
        CKS_OSC  = 2'd3
    } cksel_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HUNT    = 3'd1,
        ST_BRK_END = 3'd2,
        ST_SF_WAIT = 3'd3,
        ST_SF_MEAS = 3'd4,
        ST_DONE    = 3'd5
    } hdr_state_e;

    // event vector positions: {brk, sf, col}
    localparam int unsigned NEVT    = 3;
    localparam int unsigned EV_COL  = 0;
    localparam int unsigned EV_SF   = 1;
    localparam int unsigned EV_BRK  = 2;

    // falling edges counted after the first one of the synch byte
    localparam int unsigned SF_EDGES = 4;

    // largest divider ratio among the prescaled sources
    localparam int unsigned PRE_MAX = 8;

    function automatic logic fell(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

    function automatic logic gate_for(input hdr_state_e st, input logic early);
        case (st)
            ST_BRK_END, ST_SF_WAIT, ST_SF_MEAS: return early;
            ST_DONE:                            return 1'b1;
            default:                            return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lin_tick_gen.sv
module lin_tick_gen
    import lin_hdr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   active,
    input  cksel_e sel,
    input  logic   osc_tick,
    output logic   tick
);
    localparam int unsigned PW = $clog2(PRE_MAX);

    logic [PW-1:0] pcnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active) pcnt_q <= '0;
        else                pcnt_q <= pcnt_q + 1'b1;
    end

    always_comb begin
        tick = 1'b0;
        if (active) begin
            case (sel)
                CKS_DIV1: tick = 1'b1;
                CKS_DIV2: tick = pcnt_q[0];
                CKS_DIV8: tick = (pcnt_q == PW'(PRE_MAX - 1));
                default:  tick = osc_tick;
            endcase
        end
    end

    // R4
    div2_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && sel == CKS_DIV2) |=> !(tick && sel == CKS_DIV2));

    // R4
    div8_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && sel == CKS_DIV8) |=> !(tick && sel == CKS_DIV8));

endmodule

// File: rtl/lin_hdr_fsm.sv
module lin_hdr_fsm
    import lin_hdr_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          tick,
    input  logic          rx,
    input  logic [CW-1:0] brk_width,
    output hdr_state_e    state,
    output logic          brk_evt,
    output logic          sf_evt,
    output logic [CW-1:0] sf_count
);
    localparam int unsigned    EW   = $clog2(SF_EDGES + 1);
    localparam logic [CW-1:0]  CMAX = '1;

    hdr_state_e    st_q, st_d;
    logic [CW-1:0] dcnt_q, dcnt_d;
    logic [CW-1:0] mcnt_q, mcnt_d, mnext;
    logic [CW-1:0] cap_q, cap_d;
    logic [EW-1:0] edg_q, edg_d;
    logic          rx_prev_q, fall;

    assign fall = fell(rx_prev_q, rx);
    assign mnext = (tick && mcnt_q != CMAX) ? mcnt_q + 1'b1 : mcnt_q;

    always_comb begin
        st_d    = st_q;
        dcnt_d  = dcnt_q;
        mcnt_d  = mcnt_q;
        cap_d   = cap_q;
        edg_d   = edg_q;
        brk_evt = 1'b0;
        sf_evt  = 1'b0;
        if (!active) begin
            st_d   = ST_IDLE;
            dcnt_d = brk_width;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    st_d   = ST_HUNT;
                    dcnt_d = brk_width;
                end
                ST_HUNT, ST_DONE: begin
                    if (rx) begin
                        dcnt_d = brk_width;
                    end else if (tick) begin
                        if (dcnt_q <= CW'(1)) begin
                            brk_evt = 1'b1;
                            st_d    = ST_BRK_END;
                        end else begin
                            dcnt_d = dcnt_q - 1'b1;
                        end
                    end
                end
                ST_BRK_END: begin
                    if (rx) st_d = ST_SF_WAIT;
                end
                ST_SF_WAIT: begin
                    if (fall) begin
                        st_d   = ST_SF_MEAS;
                        mcnt_d = '0;
                        edg_d  = '0;
                    end
                end
                ST_SF_MEAS: begin
                    mcnt_d = mnext;
                    if (fall) begin
                        if (edg_q == EW'(SF_EDGES - 1)) begin
                            cap_d  = mnext;
                            sf_evt = 1'b1;
                            st_d   = ST_DONE;
                            dcnt_d = brk_width;
                        end else begin
                            edg_d = edg_q + 1'b1;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            dcnt_q    <= '0;
            mcnt_q    <= '0;
            cap_q     <= '0;
            edg_q     <= '0;
            rx_prev_q <= 1'b1;
        end else begin
            st_q      <= st_d;
            dcnt_q    <= dcnt_d;
            mcnt_q    <= mcnt_d;
            cap_q     <= cap_d;
            edg_q     <= edg_d;
            rx_prev_q <= rx;
        end
    end

    assign state    = st_q;
    assign sf_count = cap_q;

    // R1
    idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> st_q == ST_IDLE);

    // R3
    brk_to_end_chk: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> st_q == ST_BRK_END);

    // R5
    sf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DONE && !sf_evt) |=> $stable(sf_count));

endmodule

// File: rtl/lin_evt_flags.sv
module lin_evt_flags
    import lin_hdr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic            bit_sample,
    input  logic            tx,
    input  logic            rx,
    input  logic            brk_set,
    input  logic            sf_set,
    input  logic [NEVT-1:0] clr,
    input  logic [NEVT-1:0] ie,
    output logic [NEVT-1:0] flags,
    output logic            irq
);
    logic [NEVT-1:0] set_v;
    logic [NEVT-1:0] fl_q;

    assign set_v[EV_BRK] = brk_set;
    assign set_v[EV_SF]  = sf_set;
    assign set_v[EV_COL] = active & bit_sample & tx & ~rx;

    for (genvar g = 0; g < NEVT; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)            fl_q[g] <= 1'b0;
            else if (set_v[g])  fl_q[g] <= 1'b1;
            else if (clr[g])    fl_q[g] <= 1'b0;
        end
    end

    assign flags = fl_q;
    assign irq   = |(fl_q & ie);

    // R8
    sticky_brk_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_q[EV_BRK] && !clr[EV_BRK]) |=> fl_q[EV_BRK]);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (sf_set && clr[EV_SF]) |=> fl_q[EV_SF]);

    // R10
    col_set_chk: assert property (@(posedge clk) disable iff (rst)
        (active && bit_sample && tx && !rx) |=> fl_q[EV_COL]);

    // R9
    irq_sf_chk: assert property (@(posedge clk) disable iff (rst)
        (sf_set && ie[EV_SF]) |=> (irq || !ie[EV_SF]));

endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx
    import lin_hdr_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_en,
    input  logic          cfg_master,
    input  logic [1:0]    cfg_clk_sel,
    input  logic [CW-1:0] cfg_brk_width,
    input  logic          cfg_unmask_early,
    input  logic          ie_brk,
    input  logic          ie_sf,
    input  logic          ie_col,
    input  logic [2:0]    flag_clr,
    input  logic          osc_tick,
    input  logic          rx_pin,
    input  logic          tx_out,
    input  logic          bit_sample,
    output logic          uart_rxd,
    output logic          flag_brk,
    output logic          flag_sf,
    output logic          flag_col,
    output logic [CW-1:0] sf_count,
    output logic          irq
);
    logic            active, tick, brk_evt, sf_evt, gate_open;
    hdr_state_e      st;
    logic [NEVT-1:0] ie_v, flags;

    assign active = cfg_en & ~cfg_master;

    lin_tick_gen u_tick (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .sel      (cksel_e'(cfg_clk_sel)),
        .osc_tick (osc_tick),
        .tick     (tick)
    );

    lin_hdr_fsm #(.CW(CW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .tick      (tick),
        .rx        (rx_pin),
        .brk_width (cfg_brk_width),
        .state     (st),
        .brk_evt   (brk_evt),
        .sf_evt    (sf_evt),
        .sf_count  (sf_count)
    );

    assign ie_v[EV_BRK] = ie_brk;
    assign ie_v[EV_SF]  = ie_sf;
    assign ie_v[EV_COL] = ie_col;

    lin_evt_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .bit_sample (bit_sample),
        .tx         (tx_out),
        .rx         (rx_pin),
        .brk_set    (brk_evt),
        .sf_set     (sf_evt),
        .clr        (flag_clr),
        .ie         (ie_v),
        .flags      (flags),
        .irq        (irq)
    );

    assign gate_open = active & gate_for(st, cfg_unmask_early);
    assign uart_rxd  = gate_open ? rx_pin : 1'b1;

    assign flag_brk = flags[EV_BRK];
    assign flag_sf  = flags[EV_SF];
    assign flag_col = flags[EV_COL];

    // R1
    masked_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && $past(!cfg_en)) |-> uart_rxd);

    // R2
    master_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && $past(cfg_master)) |-> !(brk_evt || sf_evt));

    // R6
    late_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_unmask_early && st == ST_SF_MEAS) |-> uart_rxd);

endmodule

// File: tb/sim_lin_hdr_rx.sv
module sim_lin_hdr_rx;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_en = 1'b0, cfg_master = 1'b0, cfg_unmask_early = 1'b0;
    logic [1:0]    cfg_clk_sel = 2'd0;
    logic [CW-1:0] cfg_brk_width = 16'd10;
    logic          ie_brk = 1'b0, ie_sf = 1'b0, ie_col = 1'b0;
    logic [2:0]    flag_clr = 3'b000;
    logic          osc_tick = 1'b0, rx_pin = 1'b1, tx_out = 1'b0, bit_sample = 1'b0;
    logic          uart_rxd, flag_brk, flag_sf, flag_col, irq;
    logic [CW-1:0] sf_count;

    int checks = 0;
    int errors = 0;
    logic mid_uart;

    always #4 clk = ~clk;

    lin_hdr_rx #(.CW(CW)) u0 (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_master(cfg_master),
        .cfg_clk_sel(cfg_clk_sel), .cfg_brk_width(cfg_brk_width),
        .cfg_unmask_early(cfg_unmask_early), .ie_brk(ie_brk), .ie_sf(ie_sf),
        .ie_col(ie_col), .flag_clr(flag_clr), .osc_tick(osc_tick), .rx_pin(rx_pin),
        .tx_out(tx_out), .bit_sample(bit_sample), .uart_rxd(uart_rxd),
        .flag_brk(flag_brk), .flag_sf(flag_sf), .flag_col(flag_col),
        .sf_count(sf_count), .irq(irq)
    );

    function automatic int exp_sf(input int bitp);
        return 8 * bitp;
    endfunction

    function automatic logic exp_mid(input logic early);
        return early ? 1'b0 : 1'b1;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic level(input logic v, input int n);
        rx_pin = v;
        cyc(n);
    endtask

    task automatic clear_all();
        flag_clr = 3'b111;
        cyc(1);
        flag_clr = 3'b000;
    endtask

    task automatic send_break(input int len, input int delim);
        level(1'b1, 4);
        level(1'b0, len);
        level(1'b1, delim);
    endtask

    task automatic send_synch(input int bitp);
        rx_pin = 1'b0;
        cyc(1);
        mid_uart = uart_rxd;
        cyc(bitp - 1);
        for (int i = 0; i < 8; i++) level(((8'h55 >> i) & 1) != 0, bitp);
        level(1'b1, bitp + 2);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        cyc(150000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int r;
        r = $urandom(32'h1a5e);
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // reset state
        chk("R8 reset flags", {flag_brk, flag_sf, flag_col}, 0);
        chk("R9 reset irq", irq, 0);
        chk("R1 reset uart_rxd", uart_rxd, 1);
        chk("R5 reset sf_count", sf_count, 0);

        // R2: master mode stays idle
        cfg_master = 1'b1; cfg_en = 1'b1;
        level(1'b0, 40);
        chk("R2 no break in master mode", flag_brk, 0);
        chk("R2 uart masked in master mode", uart_rxd, 1);
        level(1'b1, 2);
        cfg_master = 1'b0;
        cyc(2);

        // R3 boundary: width-1 low, then exact width
        cfg_brk_width = 16'd10;
        level(1'b0, 9);
        chk("R3 width-1 no break", flag_brk, 0);
        level(1'b1, 3);
        level(1'b0, 10);
        chk("R3 exact width break", flag_brk, 1);

        // R6: late unmask over synch field
        cfg_unmask_early = 1'b0;
        level(1'b1, 4);
        send_synch(5);
        chk("R6 synch masked", mid_uart, 1);
        chk("R5 synch flag", flag_sf, 1);
        chk("R5 synch count", sf_count, exp_sf(5));
        rx_pin = 1'b0; cyc(1);
        chk("R6 open after measure", uart_rxd, 0);
        level(1'b1, 2);
        clear_all();

        // R7 + R11: early unmask, new header started from completed state
        cfg_unmask_early = 1'b1;
        send_break(12, 3);
        chk("R11 rearm break", flag_brk, 1);
        chk("R7 open after break high", uart_rxd, 1);
        send_synch(3);
        chk("R7 synch passed", mid_uart, 0);
        chk("R11 rearm count", sf_count, exp_sf(3));
        clear_all();

        // R1: disable mid-header, re-enable reuses config
        send_break(10, 2);
        rx_pin = 1'b0; cyc(2);
        cfg_en = 1'b0;
        #1;
        chk("R1 masked on disable", uart_rxd, 1);
        cyc(2);
        level(1'b1, 2);
        chk("R1 no synch after disable", flag_sf, 0);
        cfg_en = 1'b1; cyc(2);
        clear_all();
        send_break(10, 2);
        send_synch(4);
        chk("R1 re-enable count", sf_count, exp_sf(4));
        chk("R11 re-enable synch flag", flag_sf, 1);

        // R8: clear and set collision, W1C per bit
        flag_clr = 3'b010; cyc(1); flag_clr = 3'b000;
        chk("R8 clear sf only", {flag_brk, flag_sf}, 2'b10);
        // R9 irq enables
        ie_brk = 1'b1; #1;
        chk("R9 irq on enabled flag", irq, 1);
        ie_brk = 1'b0; #1;
        chk("R9 irq off when disabled", irq, 0);
        clear_all();

        // R10 collision combinations
        tx_out = 1'b0; bit_sample = 1'b1; rx_pin = 1'b0; cyc(1);
        bit_sample = 1'b0; rx_pin = 1'b1;
        chk("R10 tx low no collision", flag_col, 0);
        tx_out = 1'b1; bit_sample = 1'b0; rx_pin = 1'b0; cyc(1);
        rx_pin = 1'b1;
        chk("R10 no sample no collision", flag_col, 0);
        bit_sample = 1'b1; rx_pin = 1'b1; cyc(1);
        chk("R10 rx high no collision", flag_col, 0);
        rx_pin = 1'b0; cyc(1);
        bit_sample = 1'b0; rx_pin = 1'b1; tx_out = 1'b0;
        chk("R10 collision", flag_col, 1);
        ie_col = 1'b1; #1;
        chk("R9 irq from collision", irq, 1);
        // R8: clear together with new collision, set wins
        flag_clr = 3'b001; tx_out = 1'b1; bit_sample = 1'b1; rx_pin = 1'b0; cyc(1);
        flag_clr = 3'b000; tx_out = 1'b0; bit_sample = 1'b0; rx_pin = 1'b1;
        chk("R8 set wins over clear", flag_col, 1);
        flag_clr = 3'b001; cyc(1); flag_clr = 3'b000;
        chk("R8 collision cleared", flag_col, 0);
        ie_col = 1'b0;
        // line low during the collision steps must not leave a partial break
        cfg_en = 1'b0; cyc(1); cfg_en = 1'b1; cyc(2);

        // R4 divide by 2, width 5
        cfg_en = 1'b0; cfg_clk_sel = 2'd1; cfg_brk_width = 16'd5; cyc(1);
        cfg_en = 1'b1; cyc(3);
        level(1'b0, 8);
        chk("R4 div2 short low", flag_brk, 0);
        level(1'b1, 3);
        level(1'b0, 12);
        chk("R4 div2 long low", flag_brk, 1);
        level(1'b1, 2);
        clear_all();

        // R4 divide by 8, width 3
        cfg_en = 1'b0; cfg_clk_sel = 2'd2; cfg_brk_width = 16'd3; cyc(1);
        cfg_en = 1'b1; cyc(3);
        level(1'b0, 16);
        chk("R4 div8 short low", flag_brk, 0);
        level(1'b1, 3);
        level(1'b0, 32);
        chk("R4 div8 long low", flag_brk, 1);
        level(1'b1, 2);
        clear_all();

        // R4 oscillator pulses, width 2
        cfg_en = 1'b0; cfg_clk_sel = 2'd3; cfg_brk_width = 16'd2; cyc(1);
        cfg_en = 1'b1; cyc(3);
        level(1'b0, 6);
        chk("R4 osc no pulses", flag_brk, 0);
        osc_tick = 1'b1; cyc(1); osc_tick = 1'b0; cyc(2);
        chk("R4 osc one pulse", flag_brk, 0);
        osc_tick = 1'b1; cyc(1); osc_tick = 1'b0;
        chk("R4 osc two pulses", flag_brk, 1);
        level(1'b1, 2);
        clear_all();

        // random headers, undivided source
        cfg_en = 1'b0; cfg_clk_sel = 2'd0; cyc(1);
        cfg_en = 1'b1; cyc(2);
        for (int it = 0; it < 16; it++) begin
            int bitp, w, extra;
            logic early;
            bitp  = 2 + int'($urandom % 7);
            w     = 10 + int'($urandom % 15);
            extra = int'($urandom % 4);
            early = logic'($urandom % 2);
            cfg_brk_width = CW'(w);
            cfg_unmask_early = early;
            if (($urandom % 4) == 0) begin
                level(1'b1, 2);
                level(1'b0, w - 1);
                chk("R3 random short low", flag_brk, 0);
            end
            send_break(w + extra, bitp);
            chk("R3 random break", flag_brk, 1);
            send_synch(bitp);
            chk(early ? "R7 random unmask" : "R6 random mask", mid_uart, exp_mid(early));
            chk("R5 random synch count", sf_count, exp_sf(bitp));
            chk("R5 random synch flag", flag_sf, 1);
            clear_all();
            chk("R8 random clear", {flag_brk, flag_sf}, 0);
        end

        finish_run();
    end
endmodule